// File: doc/BRIEF.md
# I2C Bus Busy and Arbitration Monitor

This block watches the clock and data lines of a serial channel that runs in I2C mode. It gives a host register interface two status bits. The first is a bus-busy flag: a START condition on the lines sets it, and a STOP condition clears it. Software can also clear it by writing zero; writing one to it does nothing. The second is an arbitration-lost flag. The block produces it by comparing the data level the channel drives with the level it samples back at each rising clock edge while the channel transmits.

A control input selects one of two update policies for the arbitration flag. In the per-bit policy, every sampled bit refreshes the flag. In the per-byte policy, a loss seen on any bit of the byte is held internally, and the flag takes that value only at a byte-boundary strobe. A mode-select input turns the whole monitor on and off. While it is off, the flags keep their values and only the software clear of the busy bit still acts. The block does not generate the clock, shift data or handle ACK.

Top module: `i2cmon_top`

## Requirements
- R1: After reset, busy_o and arb_lost_o are both 0.
- R2: With i2c_mode_i=1, a START condition sets busy_o to 1. A START is sda_i going 1 to 0 while scl_i stays 1, judged after a 2-flop input synchronizer. The flag changes on the third clock edge after the pin change.
- R3: With i2c_mode_i=1, a STOP condition clears busy_o to 0. A STOP is sda_i going 0 to 1 while scl_i stays 1.
- R4: A cycle with wr_en_i=1 and wr_busy_i=0 clears busy_o. A cycle with wr_en_i=1 and wr_busy_i=1 leaves busy_o unchanged.
- R5: A change of sda_i while scl_i is 0 is neither a START nor a STOP, and a rising scl_i is neither; busy_o keeps its value.
- R6: With arb_per_byte_i=0, each synchronized rising edge of scl_i seen while tx_active_i=1 loads arb_lost_o. The value loaded is 1 when sda_drv_i=1 (released) and the sampled SDA is 0, and 0 otherwise.
- R7: With arb_per_byte_i=1, rising scl_i edges leave arb_lost_o unchanged. A loss on any bit is remembered. A one-cycle byte_end_i pulse copies the remembered loss (OR a loss in that same cycle) into arb_lost_o and clears the memory.
- R8: With i2c_mode_i=0, START, STOP, bit sampling and byte_end_i have no effect, and both flags hold their values.
- R9: While tx_active_i=0, rising scl_i edges do not change arb_lost_o.
- R10: When a START is detected in the same cycle as a software clear, busy_o ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_drv_i | input | 1 | SDA value this channel drives (1 = released) |
| tx_active_i | input | 1 | Channel is transmitting; enables the arbitration compare |
| byte_end_i | input | 1 | One-cycle strobe at each byte boundary |
| i2c_mode_i | input | 1 | 1 = monitor active (I2C mode) |
| arb_per_byte_i | input | 1 | Arbitration update policy: 0 per bit, 1 per byte |
| wr_en_i | input | 1 | Register write strobe for the busy bit |
| wr_busy_i | input | 1 | Value written to the busy bit |
| busy_o | output | 1 | Bus-busy flag |
| arb_lost_o | output | 1 | Arbitration-lost flag |

## Verification
The hardest case to reach is a START detection that falls in the same clock cycle as a software clear. Line changes pass through the synchronizer and the edge register before detection, so the bench drives SDA low and then counts exactly two clock edges before raising the write strobe for one cycle. A second hard case is the per-byte policy. There, a lost bit must leave the visible flag untouched and show up only at the strobe. The bench follows it with a clean byte to prove the internal memory was cleared.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

  // Update policy of the arbitration-lost flag
  typedef enum logic {
    ARB_PER_BIT  = 1'b0,
    ARB_PER_BYTE = 1'b1
  } arb_policy_e;

  // Line events decoded from the synchronized bus
  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
  } bus_evt_t;

endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
  parameter int              STAGES  = 2,
  parameter int              LANES   = 2,
  parameter logic [LANES-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] d_i,
  output logic [LANES-1:0] q_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;

    always_comb begin
      sh_d = {sh_q[STAGES-2:0], d_i[l]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q <= {STAGES{RST_VAL[l]}};
      end else begin
        sh_q <= sh_d;
      end
    end

    assign q_o[l] = sh_q[STAGES-1];
  end

endmodule

// File: rtl/i2cmon_cond_det.sv
module i2cmon_cond_det
  import i2cmon_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_s_i,
  input  logic     sda_s_i,
  output bus_evt_t evt_o
);

  logic scl_prev_q, scl_prev_d;
  logic sda_prev_q, sda_prev_d;

  always_comb begin
    scl_prev_d = scl_s_i;
    sda_prev_d = sda_s_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_prev_d;
      sda_prev_q <= sda_prev_d;
    end
  end

  logic scl_high_held;
  always_comb begin
    scl_high_held  = scl_s_i & scl_prev_q;
    evt_o.start    = scl_high_held & sda_prev_q & ~sda_s_i;
    evt_o.stop     = scl_high_held & ~sda_prev_q & sda_s_i;
    evt_o.scl_rise = scl_s_i & ~scl_prev_q;
  end

  // R5: no START or STOP is decoded while the synchronized clock is low
  a_r5_quiet_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_s_i |-> (!evt_o.start && !evt_o.stop));

  // R5: one decoded event at most per cycle
  a_r5_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_o.start, evt_o.stop, evt_o.scl_rise}));

endmodule

// File: rtl/i2cmon_busy_reg.sv
module i2cmon_busy_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic start_i,
  input  logic stop_i,
  input  logic wr_en_i,
  input  logic wr_val_i,
  output logic busy_o
);

  logic busy_q, busy_d, busy_ce;
  logic sw_clear, hw_start, hw_stop;

  always_comb begin
    sw_clear = wr_en_i & ~wr_val_i;
    hw_start = en_i & start_i;
    hw_stop  = en_i & stop_i;
    busy_ce  = sw_clear | hw_start | hw_stop;
    busy_d   = busy_q;
    if (sw_clear) busy_d = 1'b0;
    if (hw_stop)  busy_d = 1'b0;
    if (hw_start) busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else if (busy_ce) begin
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;

  a_r2_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && start_i) |=> busy_o);

  a_r3_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && stop_i) |=> !busy_o);

  a_r4_zero_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_val_i && !(en_i && start_i)) |=> !busy_o);

  a_r4_one_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_val_i && !(en_i && (start_i || stop_i))) |=> $stable(busy_o));

  a_r8_busy_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !(wr_en_i && !wr_val_i)) |=> $stable(busy_o));

  a_r10_start_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && start_i && wr_en_i && !wr_val_i) |=> busy_o);

endmodule

// File: rtl/i2cmon_arb_track.sv
module i2cmon_arb_track
  import i2cmon_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_i,
  input  logic        tx_active_i,
  input  arb_policy_e policy_i,
  input  logic        scl_rise_i,
  input  logic        drv_sda_i,
  input  logic        sda_s_i,
  input  logic        byte_end_i,
  output logic        arb_lost_o
);

  logic sample_ok, bit_lost, byte_tick;
  logic flag_q, flag_d, flag_ce;
  logic pend_q, pend_d, pend_ce;

  always_comb begin
    sample_ok = en_i & tx_active_i & scl_rise_i;
    bit_lost  = sample_ok & drv_sda_i & ~sda_s_i;
    byte_tick = en_i & byte_end_i;

    flag_d  = flag_q;
    flag_ce = 1'b0;
    pend_d  = pend_q;
    pend_ce = 1'b0;

    unique case (policy_i)
      ARB_PER_BIT: begin
        flag_ce = sample_ok;
        flag_d  = bit_lost;
        pend_ce = pend_q;
        pend_d  = 1'b0;
      end
      ARB_PER_BYTE: begin
        flag_ce = byte_tick;
        flag_d  = pend_q | bit_lost;
        pend_ce = byte_tick | bit_lost;
        pend_d  = ~byte_tick & bit_lost | ~byte_tick & pend_q;
      end
      default: begin
        flag_ce = 1'b0;
        pend_ce = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_ce) begin
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_ce) begin
      pend_q <= pend_d;
    end
  end

  assign arb_lost_o = flag_q;

  a_r6_bit_loss_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (policy_i == ARB_PER_BIT && en_i && tx_active_i && scl_rise_i && drv_sda_i && !sda_s_i)
    |=> arb_lost_o);

  a_r6_bit_win_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (policy_i == ARB_PER_BIT && en_i && tx_active_i && scl_rise_i && !(drv_sda_i && !sda_s_i))
    |=> !arb_lost_o);

  a_r7_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (policy_i == ARB_PER_BYTE && !(en_i && byte_end_i)) |=> $stable(arb_lost_o));

  a_r7_byte_copy_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (policy_i == ARB_PER_BYTE && en_i && byte_end_i && pend_q) |=> arb_lost_o);

  a_r8_arb_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(arb_lost_o));

  a_r9_no_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (policy_i == ARB_PER_BIT && !tx_active_i) |=> $stable(arb_lost_o));

endmodule

// File: rtl/i2cmon_top.sv
module i2cmon_top
  import i2cmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic sda_drv_i,
  input  logic tx_active_i,
  input  logic byte_end_i,
  input  logic i2c_mode_i,
  input  logic arb_per_byte_i,
  input  logic wr_en_i,
  input  logic wr_busy_i,
  output logic busy_o,
  output logic arb_lost_o
);

  localparam int LINE_CNT = 2;
  localparam int SCL_IDX  = 0;
  localparam int SDA_IDX  = 1;

  // Reset: asserted asynchronously, released through a short flop chain
  logic [RST_STAGES-1:0] rst_pipe_q, rst_pipe_d;
  logic                  rst_n_int;

  if (RST_STAGES > 1) begin : g_rst_chain
    always_comb rst_pipe_d = {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end else begin : g_rst_single
    always_comb rst_pipe_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= rst_pipe_d;
    end
  end

  assign rst_n_int = rst_pipe_q[RST_STAGES-1];

  // Line synchronizers (bus idles high)
  logic [LINE_CNT-1:0] lines_raw, lines_s;
  assign lines_raw[SCL_IDX] = scl_i;
  assign lines_raw[SDA_IDX] = sda_i;

  i2cmon_sync #(
    .STAGES (SYNC_STAGES),
    .LANES  (LINE_CNT),
    .RST_VAL({LINE_CNT{1'b1}})
  ) sync_i (
    .clk  (clk),
    .rst_n(rst_n_int),
    .d_i  (lines_raw),
    .q_o  (lines_s)
  );

  bus_evt_t evt;

  i2cmon_cond_det cond_i (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .scl_s_i(lines_s[SCL_IDX]),
    .sda_s_i(lines_s[SDA_IDX]),
    .evt_o  (evt)
  );

  i2cmon_busy_reg busy_i (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .en_i    (i2c_mode_i),
    .start_i (evt.start),
    .stop_i  (evt.stop),
    .wr_en_i (wr_en_i),
    .wr_val_i(wr_busy_i),
    .busy_o  (busy_o)
  );

  arb_policy_e policy;
  assign policy = arb_policy_e'(arb_per_byte_i);

  i2cmon_arb_track arb_i (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .en_i       (i2c_mode_i),
    .tx_active_i(tx_active_i),
    .policy_i   (policy),
    .scl_rise_i (evt.scl_rise),
    .drv_sda_i  (sda_drv_i),
    .sda_s_i    (lines_s[SDA_IDX]),
    .byte_end_i (byte_end_i),
    .arb_lost_o (arb_lost_o)
  );

endmodule

// File: tb/i2cmon_top_tb_top.sv
module i2cmon_top_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, drv = 1'b1, tx = 1'b0, bend = 1'b0;
  logic mode = 1'b0, per_byte = 1'b0, wr_en = 1'b0, wr_val = 1'b0;
  logic busy, arb;

  always #4 clk = ~clk;  // 125 MHz

  i2cmon_top dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_drv_i(drv),
    .tx_active_i(tx), .byte_end_i(bend), .i2c_mode_i(mode),
    .arb_per_byte_i(per_byte), .wr_en_i(wr_en), .wr_busy_i(wr_val),
    .busy_o(busy), .arb_lost_o(arb)
  );

  typedef struct {
    string tag;
    logic  busy;
    logic  arb;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expect_state(string tag, logic b, logic a);
    exp_t e;
    tick(5);
    e.tag = tag; e.busy = b; e.arb = a;
    exp_q.push_back(e);
  endtask

  // Monitor: pops expectations and compares at the falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (busy !== e.busy || arb !== e.arb) begin
        n_fail++;
        $display("FAIL %s: busy/arb got %b/%b expected %b/%b",
                 e.tag, busy, arb, e.busy, e.arb);
      end
    end
  end

  task automatic line(logic c, logic d);
    scl = c; sda = d;
    tick(4);
  endtask

  // One data bit: set levels while SCL is low, then raise SCL
  task automatic send_bit(logic drive, logic level);
    scl = 1'b0; tick(4);
    drv = drive; sda = level; tick(4);
    scl = 1'b1; tick(4);
  endtask

  task automatic strobe_byte();
    bend = 1'b1; tick(1); bend = 1'b0;
  endtask

  task automatic sw_write(logic v);
    wr_val = v; wr_en = 1'b1; tick(1); wr_en = 1'b0;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(4);
    expect_state("R1 reset", 1'b0, 1'b0);

    mode = 1'b1;
    line(1'b1, 1'b0);
    expect_state("R2 start", 1'b1, 1'b0);
    sw_write(1'b1);
    expect_state("R4 write one ignored", 1'b1, 1'b0);
    sw_write(1'b0);
    expect_state("R4 write zero clears", 1'b0, 1'b0);

    line(1'b0, 1'b0); line(1'b0, 1'b1); line(1'b1, 1'b1);
    line(1'b1, 1'b0);
    expect_state("R2 start again", 1'b1, 1'b0);
    line(1'b0, 1'b0); line(1'b0, 1'b1);
    expect_state("R5 sda rise, scl low", 1'b1, 1'b0);
    line(1'b0, 1'b0);
    line(1'b1, 1'b0);
    expect_state("R5 scl rise", 1'b1, 1'b0);
    line(1'b1, 1'b1);
    expect_state("R3 stop", 1'b0, 1'b0);
    line(1'b0, 1'b1); line(1'b0, 1'b0);
    expect_state("R5 sda fall, scl low", 1'b0, 1'b0);
    line(1'b1, 1'b0);
    line(1'b1, 1'b1);
    expect_state("R3 stop when idle", 1'b0, 1'b0);

    // Per-bit arbitration
    tx = 1'b1; per_byte = 1'b0;
    send_bit(1'b1, 1'b0);
    expect_state("R6 loss", 1'b0, 1'b1);
    send_bit(1'b1, 1'b1);
    expect_state("R6 refresh on win", 1'b0, 1'b0);
    send_bit(1'b0, 1'b0);
    expect_state("R6 driving low", 1'b0, 1'b0);
    send_bit(1'b1, 1'b0);
    expect_state("R6 loss again", 1'b0, 1'b1);
    tx = 1'b0;
    send_bit(1'b1, 1'b1);
    expect_state("R9 no tx hold 1", 1'b0, 1'b1);
    tx = 1'b1;
    send_bit(1'b1, 1'b1);
    tx = 1'b0;
    send_bit(1'b1, 1'b0);
    expect_state("R9 no tx hold 0", 1'b0, 1'b0);

    // Per-byte arbitration
    tx = 1'b1; per_byte = 1'b1;
    send_bit(1'b1, 1'b0);
    expect_state("R7 loss held back", 1'b0, 1'b0);
    send_bit(1'b1, 1'b1);
    expect_state("R7 win does not refresh", 1'b0, 1'b0);
    strobe_byte();
    expect_state("R7 copy at strobe", 1'b0, 1'b1);
    send_bit(1'b1, 1'b1);
    send_bit(1'b0, 1'b0);
    expect_state("R7 hold between strobes", 1'b0, 1'b1);
    strobe_byte();
    expect_state("R7 memory cleared", 1'b0, 1'b0);

    // Monitor disabled
    send_bit(1'b1, 1'b0);
    mode = 1'b0;
    strobe_byte();
    expect_state("R8 strobe ignored", 1'b0, 1'b0);
    per_byte = 1'b0;
    send_bit(1'b1, 1'b0);
    expect_state("R8 bit ignored", 1'b0, 1'b0);
    line(1'b1, 1'b1); line(1'b1, 1'b0);
    expect_state("R8 start ignored", 1'b0, 1'b0);
    line(1'b0, 1'b0); line(1'b0, 1'b1); line(1'b1, 1'b1);
    tx = 1'b0; drv = 1'b1;
    mode = 1'b1;
    per_byte = 1'b1;
    strobe_byte();
    expect_state("R8 no memory kept while off", 1'b0, 1'b0);
    per_byte = 1'b0;

    // START and software clear in the same cycle
    sda = 1'b0;
    tick(2);
    sw_write(1'b0);
    expect_state("R10 start wins", 1'b1, 1'b0);
    line(1'b1, 1'b1);
    expect_state("R3 final stop", 1'b0, 1'b0);

    tick(3);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule